// File: doc/BRIEF.md
# Fibre Permit Loop Carrier Generator and Monitor

This block sits at the dump end of four fibre permit loops. Each beam has two loops, one clockwise and one anticlockwise, and the two beams are handled independently. For each loop the block sends out a square-wave carrier with a nominal period of 100 ns, which is `2*HALF_CYC` system clock cycles. It watches the loop's return line and keeps the loop latched for as long as a carrier of the right frequency keeps coming back. Each return line passes through a two-flop synchroniser before any edge is taken from it.

A loop can only be started inside a self-timed initialisation window of `INIT_CYC` cycles (about 250 µs). The window opens when a beam's init request is raised while that beam's local permit is already true. During the window the loop drives its carrier. It latches only if its return input shows a valid carrier before the window closes. A latched loop that loses its carrier, or whose beam loses its local permit, drops its latch and stops driving. It stays dark until a new window is opened. Each beam has a permit output, true while both of its loops are latched, and a sticky dump request that is set whenever one of its loops leaves the latched state.

Beam FSM states: `B_IDLE` (waiting), `B_PULSE` (window open), `B_HOLD` (request still high or rejected). Its transitions are:
- start: `B_IDLE` to `B_PULSE`, when the request is high and the permit is high.
- reject: `B_IDLE` to `B_HOLD`, when the request is high and the permit is low.
- expire: `B_PULSE` to `B_IDLE` or `B_HOLD`, after `INIT_CYC` cycles.
- release: `B_HOLD` to `B_IDLE`, when the request is low.

Loop FSM states: `L_OFF`, `L_ARM`, `L_LATCHED`. Its transitions are:
- arm: `L_OFF` to `L_ARM`, in the first window cycle.
- catch: `L_ARM` to `L_LATCHED`, when the carrier is present.
- miss: `L_ARM` to `L_OFF`, when the window ends or the permit is low.
- trip: `L_LATCHED` to `L_OFF`, when the carrier is absent or the permit is low.

Top module: `plc_permit_loop`

## Requirements
- R1: Loop index i belongs to beam i/2. Loops 0 and 1 are the clockwise and anticlockwise loops of the first beam, and loops 2 and 3 are those of the second beam. Bit b of every per-beam port refers to beam b.
- R2: While a loop is arming or latched, `carrier_drv[i]` is a square wave that toggles every `HALF_CYC` cycles (4 toggles in any 40 cycles by default). Otherwise it is held low.
- R3: A window opens only if `local_permit[b]` is high when the FSM in `B_IDLE` sees `init_req[b]` high. A request seen while the permit is low is ignored until the request has been released, even if the permit rises meanwhile.
- R4: A window lasts exactly `INIT_CYC` cycles, however long the request stays high. A request held high after the window closes does not open another one.
- R5: A loop latches only if its carrier is recognised as present while its window is open. If not, it returns to off when the window closes and stays off even if a valid carrier appears later.
- R6: The carrier counts as present after two successive rising edges of the synchronised return are spaced between `PER_MIN` and `PER_MAX` cycles (16 to 24 by default, ±20 % of nominal). It counts as absent after `3*HALF_CYC` cycles with no edge, or after one rising-edge spacing outside that range.
- R7: When a latched loop's carrier goes absent, the latch clears and the drive stops. The loop remains off until a new window.
- R8: When `local_permit[b]` drops, any latched loop of beam b clears on the next clock edge.
- R9: `beam_permit[b]` is high exactly while both loops of beam b are latched.
- R10: `dump_req[b]` is set in the cycle in which a loop of beam b leaves the latched state. It clears only on reset, or one cycle after both loops of beam b are latched. Setting takes priority over clearing.
- R11: Inits, trips, permits and dump requests of one beam have no effect on the other beam.
- R12: After a synchronous reset (`rst` high), every loop is off, all drives are low, and no permit or dump request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| init_req | input | 2 | Per-beam loop initialisation request |
| local_permit | input | 2 | Per-beam local permit |
| carrier_ret | input | 4 | Asynchronous carrier return line of each loop |
| carrier_drv | output | 4 | Outgoing carrier of each loop |
| loop_latched | output | 4 | Loop latched status |
| beam_permit | output | 2 | Both loops of the beam latched |
| dump_req | output | 2 | Sticky per-beam dump request |

## Verification
The assertions assume that `rst` is synchronous. They also assume that the return lines carry only what the fibre gives back: a delayed copy of the loop's own drive, a dark line, or a clean square wave from elsewhere. Any of these may change at any time. The bench drives its requests and permits one nanosecond after a rising edge and switches the fibre model at falling edges. Before it compares, it gives each change at least a full detection interval to settle, so the checks do not depend on exact edge alignment within the synchroniser.

// File: rtl/plc_pkg.sv
`timescale 1ns/1ps
package plc_pkg;

    localparam int NUM_BEAMS = 2;
    localparam int LOOPS_PER_BEAM = 2;
    localparam int NUM_LOOPS = NUM_BEAMS * LOOPS_PER_BEAM;

    typedef enum logic [1:0] {
        L_OFF     = 2'd0,
        L_ARM     = 2'd1,
        L_LATCHED = 2'd2
    } loop_st_e;

    typedef enum logic [1:0] {
        B_IDLE  = 2'd0,
        B_PULSE = 2'd1,
        B_HOLD  = 2'd2
    } beam_st_e;

    // bits needed to hold the value max_val
    function automatic int width_for(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/plc_sync2.sv
`timescale 1ns/1ps
module plc_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/plc_carrier_det.sv
`timescale 1ns/1ps
module plc_carrier_det #(
    parameter int HALF_CYC = 10,
    parameter int TOL_PCT  = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic ret_sync,
    output logic present
);

    localparam int PER_NOM = 2 * HALF_CYC;
    localparam int PER_MIN = (PER_NOM * (100 - TOL_PCT) + 99) / 100;
    localparam int PER_MAX = (PER_NOM * (100 + TOL_PCT)) / 100;
    localparam int PER_SAT = PER_MAX + 1;
    localparam int GAP_LIM = 3 * HALF_CYC;
    localparam int PW = plc_pkg::width_for(PER_SAT);
    localparam int GW = plc_pkg::width_for(GAP_LIM);

    localparam logic [PW-1:0] PMIN_C = PW'(PER_MIN);
    localparam logic [PW-1:0] PMAX_C = PW'(PER_MAX);
    localparam logic [PW-1:0] PSAT_C = PW'(PER_SAT);
    localparam logic [GW-1:0] GLIM_C = GW'(GAP_LIM);

    logic          prev;
    logic          seen_rise;
    logic [PW-1:0] per_cnt;
    logic [GW-1:0] gap_cnt;
    logic          rise;
    logic          any_edge;
    logic          per_in_range;

    assign rise         = ret_sync & ~prev;
    assign any_edge     = ret_sync ^ prev;
    assign per_in_range = (per_cnt >= PMIN_C) && (per_cnt <= PMAX_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev      <= 1'b0;
            seen_rise <= 1'b0;
            per_cnt   <= '0;
            gap_cnt   <= '0;
            present   <= 1'b0;
        end else begin
            prev <= ret_sync;

            if (any_edge) begin
                gap_cnt <= '0;
            end else if (gap_cnt != GLIM_C) begin
                gap_cnt <= gap_cnt + 1'b1;
            end

            if (rise) begin
                per_cnt   <= PW'(1);
                seen_rise <= 1'b1;
                if (seen_rise) begin
                    present <= per_in_range;
                end
            end else if (per_cnt != PSAT_C) begin
                per_cnt <= per_cnt + 1'b1;
            end

            // silence on the line wins over everything
            if (gap_cnt == GLIM_C) begin
                present   <= 1'b0;
                seen_rise <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/plc_loop_ctl.sv
`timescale 1ns/1ps
module plc_loop_ctl
    import plc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic init_first,
    input  logic init_busy,
    input  logic permit,
    input  logic present,
    input  logic phase,
    output logic drv,
    output logic latched,
    output logic trip
);

    loop_st_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= L_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            L_OFF: begin
                if (init_first) begin
                    state_nxt = L_ARM;
                end
            end
            L_ARM: begin
                if (!permit || !init_busy) begin
                    state_nxt = L_OFF;
                end else if (present) begin
                    state_nxt = L_LATCHED;
                end
            end
            L_LATCHED: begin
                if (!permit || !present) begin
                    state_nxt = L_OFF;
                end
            end
            default: state_nxt = L_OFF;
        endcase
    end

    assign latched = (state == L_LATCHED);
    assign trip    = (state == L_LATCHED) && (state_nxt != L_LATCHED);

    always_ff @(posedge clk) begin
        if (rst) begin
            drv <= 1'b0;
        end else begin
            drv <= ((state == L_ARM) || (state == L_LATCHED)) ? phase : 1'b0;
        end
    end

endmodule

// File: rtl/plc_beam_ctl.sv
`timescale 1ns/1ps
module plc_beam_ctl
    import plc_pkg::*;
#(
    parameter int INIT_CYC = 50000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       permit,
    input  logic [1:0] pair_latched,
    input  logic [1:0] pair_trip,
    output logic       init_busy,
    output logic       init_first,
    output logic       dump
);

    localparam int CW = width_for(INIT_CYC - 1);
    localparam logic [CW-1:0] LAST_C = CW'(INIT_CYC - 1);

    beam_st_e      state, state_nxt;
    logic [CW-1:0] cnt;
    logic          win_end;

    assign win_end = (state == B_PULSE) && (cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= B_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            B_IDLE: begin
                if (req && permit) begin
                    state_nxt = B_PULSE;
                end else if (req) begin
                    state_nxt = B_HOLD;
                end
            end
            B_PULSE: begin
                if (win_end) begin
                    state_nxt = req ? B_HOLD : B_IDLE;
                end
            end
            B_HOLD: begin
                if (!req) begin
                    state_nxt = B_IDLE;
                end
            end
            default: state_nxt = B_IDLE;
        endcase
    end

    assign init_busy  = (state == B_PULSE);
    assign init_first = (state == B_PULSE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            dump <= 1'b0;
        end else begin
            if (state != B_PULSE || win_end) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end

            if (|pair_trip) begin
                dump <= 1'b1;
            end else if (&pair_latched) begin
                dump <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/plc_permit_loop.sv
`timescale 1ns/1ps
module plc_permit_loop
    import plc_pkg::*;
#(
    parameter int HALF_CYC = 10,
    parameter int INIT_CYC = 50000,
    parameter int TOL_PCT  = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] init_req,
    input  logic [1:0] local_permit,
    input  logic [3:0] carrier_ret,
    output logic [3:0] carrier_drv,
    output logic [3:0] loop_latched,
    output logic [1:0] beam_permit,
    output logic [1:0] dump_req
);

    localparam int HCW = width_for(HALF_CYC - 1);
    localparam logic [HCW-1:0] HLAST_C = HCW'(HALF_CYC - 1);

    logic [HCW-1:0]           ph_cnt;
    logic                     phase;
    logic [NUM_BEAMS-1:0]     init_busy;
    logic [NUM_BEAMS-1:0]     init_first;
    logic [NUM_LOOPS-1:0]     ret_sync;
    logic [NUM_LOOPS-1:0]     present;
    logic [NUM_LOOPS-1:0]     trip;

    // shared carrier phase, one toggle per half period
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_cnt <= '0;
            phase  <= 1'b0;
        end else if (ph_cnt == HLAST_C) begin
            ph_cnt <= '0;
            phase  <= ~phase;
        end else begin
            ph_cnt <= ph_cnt + 1'b1;
        end
    end

    for (genvar b = 0; b < NUM_BEAMS; b++) begin : g_beam
        plc_beam_ctl #(
            .INIT_CYC (INIT_CYC)
        ) u_beam (
            .clk          (clk),
            .rst          (rst),
            .req          (init_req[b]),
            .permit       (local_permit[b]),
            .pair_latched (loop_latched[2*b+1:2*b]),
            .pair_trip    (trip[2*b+1:2*b]),
            .init_busy    (init_busy[b]),
            .init_first   (init_first[b]),
            .dump         (dump_req[b])
        );
        assign beam_permit[b] = &loop_latched[2*b+1:2*b];
    end

    for (genvar i = 0; i < NUM_LOOPS; i++) begin : g_loop
        plc_sync2 u_sync (
            .clk     (clk),
            .rst     (rst),
            .d_async (carrier_ret[i]),
            .q_sync  (ret_sync[i])
        );

        plc_carrier_det #(
            .HALF_CYC (HALF_CYC),
            .TOL_PCT  (TOL_PCT)
        ) u_det (
            .clk      (clk),
            .rst      (rst),
            .ret_sync (ret_sync[i]),
            .present  (present[i])
        );

        plc_loop_ctl u_loop (
            .clk        (clk),
            .rst        (rst),
            .init_first (init_first[i/LOOPS_PER_BEAM]),
            .init_busy  (init_busy[i/LOOPS_PER_BEAM]),
            .permit     (local_permit[i/LOOPS_PER_BEAM]),
            .present    (present[i]),
            .phase      (phase),
            .drv        (carrier_drv[i]),
            .latched    (loop_latched[i]),
            .trip       (trip[i])
        );
    end

endmodule

// File: rtl/plc_permit_loop_chk.sv
`timescale 1ns/1ps
module plc_permit_loop_chk #(
    parameter int INIT_CYC = 50000
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] init_busy,
    input logic [3:0] carrier_drv,
    input logic [3:0] loop_latched,
    input logic [1:0] beam_permit,
    input logic [1:0] dump_req
);

    int unsigned busy_run [2];

    for (genvar b = 0; b < 2; b++) begin : g_b
        always_ff @(posedge clk) begin
            if (rst) begin
                busy_run[b] <= 0;
            end else if (init_busy[b]) begin
                busy_run[b] <= busy_run[b] + 1;
            end else begin
                busy_run[b] <= 0;
            end
        end

        assert_window_len_R4: assert property (@(posedge clk) disable iff (rst)
            busy_run[b] <= INIT_CYC);

        assert_dump_clear_R10: assert property (@(posedge clk) disable iff (rst)
            ($fell(dump_req[b]) && !$past(rst)) |-> $past(beam_permit[b]));

        assert_permit_no_dump_R10: assert property (@(posedge clk) disable iff (rst)
            ($past(beam_permit[b]) && beam_permit[b]) |-> !dump_req[b]);
    end

    for (genvar i = 0; i < 4; i++) begin : g_l
        assert_drv_quiet_R2: assert property (@(posedge clk) disable iff (rst)
            (carrier_drv[i] && !$past(loop_latched[i])) |-> $past(init_busy[i/2], 2));

        assert_latch_in_window_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(loop_latched[i]) |-> $past(init_busy[i/2]));

        assert_dump_on_loss_R10: assert property (@(posedge clk) disable iff (rst)
            ($fell(loop_latched[i]) && !$past(rst)) |-> dump_req[i/2]);
    end

endmodule

bind plc_permit_loop plc_permit_loop_chk #(
    .INIT_CYC (INIT_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .init_busy    (init_busy),
    .carrier_drv  (carrier_drv),
    .loop_latched (loop_latched),
    .beam_permit  (beam_permit),
    .dump_req     (dump_req)
);

// File: tb/plc_permit_loop_tb.sv
`timescale 1ns/1ps
module plc_permit_loop_tb;

    localparam int HALF = 10;
    localparam int WIN  = 200;
    localparam int TOL  = 20;

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] init_req;
    logic [1:0] local_permit;
    logic [3:0] carrier_ret;
    logic [3:0] carrier_drv;
    logic [3:0] loop_latched;
    logic [1:0] beam_permit;
    logic [1:0] dump_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [3:0] exp_lat;
    logic [1:0] dump_exp;

    // fibre model: 0 loopback, 1 dark, 2 foreign square wave
    int         fmode [4];
    int         fhalf [4];
    int         fcnt  [4];
    logic [3:0] fwave;
    logic [7:0] dl    [4];
    int         nmode [4];
    int         nhalf [4];

    plc_permit_loop #(
        .HALF_CYC (HALF),
        .INIT_CYC (WIN),
        .TOL_PCT  (TOL)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .init_req     (init_req),
        .local_permit (local_permit),
        .carrier_ret  (carrier_ret),
        .carrier_drv  (carrier_drv),
        .loop_latched (loop_latched),
        .beam_permit  (beam_permit),
        .dump_req     (dump_req)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            dl[i] = {dl[i][6:0], carrier_drv[i]};
            if (fcnt[i] >= fhalf[i] - 1) begin
                fcnt[i] = 0;
                fwave[i] = ~fwave[i];
            end else begin
                fcnt[i] = fcnt[i] + 1;
            end
            case (fmode[i])
                0:       carrier_ret[i] = dl[i][2];
                1:       carrier_ret[i] = 1'b0;
                default: carrier_ret[i] = fwave[i];
            endcase
        end
    end

    task automatic report();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R6: spacing of 2*h cycles must fall within 16..24 (nominal 20, +/-20 %)
    function automatic bit period_ok(input int h);
        int pmin, pmax;
        pmin = (2 * HALF * (100 - TOL) + 99) / 100;
        pmax = (2 * HALF * (100 + TOL)) / 100;
        return (2 * h >= pmin) && (2 * h <= pmax);
    endfunction

    function automatic bit fibre_good(input int m, input int h);
        return (m == 0) || (m == 2 && period_ok(h));
    endfunction

    // R9: permit is the AND of each beam's pair
    function automatic logic [1:0] exp_bp();
        return {exp_lat[3] & exp_lat[2], exp_lat[1] & exp_lat[0]};
    endfunction

    task automatic check_state(input string req);
        chk(loop_latched == exp_lat, {req, " latched"}, int'(loop_latched), int'(exp_lat));
        chk(beam_permit == exp_bp(), {req, " R9 permit"}, int'(beam_permit), int'(exp_bp()));
        chk(dump_req == dump_exp, {req, " R10 dump"}, int'(dump_req), int'(dump_exp));
    endtask

    task automatic check_quiet(input logic [3:0] mask, input int n, input string req);
        int highs;
        highs = 0;
        for (int k = 0; k < n; k++) begin
            if ((carrier_drv & mask) != 4'b0) highs++;
            tick(1);
        end
        chk(highs == 0, req, highs, 0);
    endtask

    task automatic teardown();
        for (int i = 0; i < 4; i++) fmode[i] = 1;
        for (int b = 0; b < 2; b++) begin
            if (exp_lat[2*b] || exp_lat[2*b+1]) dump_exp[b] = 1'b1;
        end
        exp_lat = 4'b0;
        tick(60);
        check_state("R7 R10 teardown");
        check_quiet(4'hF, 25, "R2 R7 drive quiet after loss");
    endtask

    task automatic pulse_init(input logic [1:0] which);
        init_req = init_req | which;
        tick(3);
        init_req = init_req & ~which;
    endtask

    task automatic run_case(input logic [1:0] perm, input string req);
        teardown();
        for (int i = 0; i < 4; i++) begin
            fmode[i] = nmode[i];
            fhalf[i] = nhalf[i];
        end
        local_permit = perm;
        tick(40);
        pulse_init(2'b11);
        tick(WIN + 40);
        for (int i = 0; i < 4; i++) begin
            exp_lat[i] = perm[i/2] && fibre_good(nmode[i], nhalf[i]);
        end
        for (int b = 0; b < 2; b++) begin
            if (exp_lat[2*b] && exp_lat[2*b+1]) dump_exp[b] = 1'b0;
        end
        check_state(req);
    endtask

    task automatic set_all(input int m, input int h);
        for (int i = 0; i < 4; i++) begin
            nmode[i] = m;
            nhalf[i] = h;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            report();
        end
    end

    initial begin
        int toggles;
        int hlist [7];
        logic prev_d;
        hlist = '{7, 8, 10, 12, 13, 5, 16};
        void'($urandom(32'd20251));
        for (int i = 0; i < 4; i++) begin
            fmode[i] = 1; fhalf[i] = 10; fcnt[i] = 0; dl[i] = 8'h00;
        end
        fwave = 4'b0;
        carrier_ret = 4'b0;
        rst = 1'b1;
        init_req = 2'b00;
        local_permit = 2'b00;
        exp_lat = 4'b0;
        dump_exp = 2'b0;
        tick(6);
        rst = 1'b0;
        tick(2);

        // R12: reset state
        check_state("R12 reset");
        check_quiet(4'hF, 20, "R12 drive low after reset");

        // R5: all loops return their own carrier
        set_all(0, 10);
        run_case(2'b11, "R5 R1 loopback");

        // R2: carrier waveform while latched
        toggles = 0;
        prev_d = carrier_drv[0];
        for (int k = 0; k < 40; k++) begin
            tick(1);
            if (carrier_drv[0] != prev_d) toggles++;
            prev_d = carrier_drv[0];
        end
        chk(toggles == 4, "R2 carrier toggles", toggles, 4);

        // R8 R11: permit of beam 0 drops
        local_permit[0] = 1'b0;
        tick(5);
        exp_lat[1:0] = 2'b00;
        dump_exp[0] = 1'b1;
        check_state("R8 R11 permit drop");
        check_quiet(4'h3, 20, "R7 drive stops after permit drop");
        local_permit[0] = 1'b1;

        // R4: held request does not reopen the window
        init_req[1] = 1'b1;
        tick(WIN + 10);
        check_state("R4 held request over latched loops");
        fmode[2] = 1;
        tick(60);
        exp_lat[2] = 1'b0;
        dump_exp[1] = 1'b1;
        check_state("R4 R11 one loop lost");
        fmode[2] = 0;
        tick(WIN + 40);
        check_state("R4 no retrigger");
        init_req[1] = 1'b0;
        tick(5);

        // R3: request raised with permit low is ignored
        teardown();
        for (int i = 0; i < 4; i++) fmode[i] = 0;
        local_permit = 2'b10;
        tick(20);
        init_req[0] = 1'b1;
        tick(5);
        local_permit = 2'b11;
        tick(WIN + 40);
        check_state("R3 rejected request");
        check_quiet(4'h3, 20, "R3 no drive after rejection");
        init_req[0] = 1'b0;
        tick(5);

        // R5: carrier appearing after the window is too late
        teardown();
        local_permit = 2'b11;
        pulse_init(2'b11);
        tick(WIN + 20);
        for (int i = 0; i < 4; i++) begin
            fhalf[i] = 10;
            fmode[i] = 2;
        end
        tick(80);
        check_state("R5 late carrier");

        // R6: period boundaries 14, 16, 24, 26 cycles
        nmode = '{2, 2, 2, 2};
        nhalf = '{7, 8, 12, 13};
        run_case(2'b11, "R6 period bounds");

        // R6 R7: frequency drift on a latched loop
        set_all(0, 10);
        run_case(2'b11, "R6 relatch");
        fhalf[1] = 13;
        fmode[1] = 2;
        tick(80);
        exp_lat[1] = 1'b0;
        dump_exp[0] = 1'b1;
        check_state("R6 R7 drift trip");

        // constrained random cases
        for (int it = 0; it < 20; it++) begin
            logic [1:0] perm;
            for (int i = 0; i < 4; i++) begin
                int r;
                r = int'($urandom_range(0, 9));
                nmode[i] = (r < 5) ? 0 : (r < 7) ? 1 : 2;
                nhalf[i] = hlist[$urandom_range(0, 6)];
            end
            perm[0] = ($urandom_range(0, 4) != 0);
            perm[1] = ($urandom_range(0, 4) != 0);
            run_case(perm, "R5 R6 R10 R11 random");
        end

        teardown();
        finished = 1;
        report();
    end

endmodule